// File: doc/BRIEF.md
# Dual-Mode Five-Requester Bus Arbiter

This block decides which of five requesters owns a shared bus. Requester 0 is the local controller and requesters 1 to 4 are external devices. Each requester raises its own request line. The arbiter drives a one-hot grant vector that is registered, so a grant appears on the clock edge after the cycle in which the decision is made. A new decision is made only while the bus is idle (no grant held) or in a cycle where an access-done pulse marks the end of the current transfer. A grant is therefore never taken away in the middle of an access.

Two arbitration schemes can be selected while the block runs. In fixed mode the lowest-numbered requester always wins. In rotating mode the requester that last won drops to the bottom of the order, and the requester after it moves to the top. The scheme is chosen by a mode bit in a small control register. That register accepts a write only when the top byte of the write data carries a key value. When the host input is low, the block grants nothing and the mode bit has no effect.

Top module: `hostbus_arbiter`

## Requirements
- R1: After reset, `gnt_o` is all zeros and `cfg_rdata_o` reads 0, which means fixed mode. The rotating order starts with requester 0 highest.
- R2: `gnt_o` is zero or one-hot. A bit can only become set for a requester whose request was high in the arbitration cycle.
- R3: In fixed mode (mode bit 0), the active request with the lowest index wins. Requester 0 beats every other requester.
- R4: In rotating mode (mode bit 1), after a grant to requester k, the search order at the next arbitration is k+1, k+2, …, wrapping from 4 to 0, and ends at k. The rotation state advances only on a grant made in rotating mode.
- R5: Arbitration happens only in a cycle where `gnt_o` is zero or `access_done_i` is high. In every other cycle `gnt_o` holds its value, whatever the request lines do.
- R6: While `host_mode_i` is low, `gnt_o` is all zeros from the next cycle on. Neither the mode bit nor the request lines have any effect, and the rotation state is left unchanged.
- R7: A write (`cfg_we_i` high) updates the mode bit from data bit 0 only when `cfg_wdata_i[31:24]` equals 0xA5. Any other write is discarded.
- R8: `cfg_rdata_o` carries the mode bit in bit 0. Bits 31 to 1 always read 0, including the key byte.
- R9: At an arbitration point with no active request, `gnt_o` goes to all zeros and the rotation state is unchanged.
- R10: A mode written during an access is used from the next arbitration point. A mode written in the same cycle as an arbitration is not used by that arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_mode_i | input | 1 | High when the block acts as host and may grant |
| req_i | input | 5 | Request line per requester, bit i for requester i |
| access_done_i | input | 1 | One-cycle pulse at the end of the current access |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 32 | Control register write data: key in [31:24], mode in [0] |
| cfg_rdata_o | output | 32 | Control register readback |
| gnt_o | output | 5 | One-hot grant vector |

## Verification
The bench builds the block with its default parameters: five requesters, a 32-bit write port and the key 0xA5 in the top byte. A reference model in the bench runs beside the design and is compared on every cycle. This makes two things reachable:
- With all five requesters active, the rotating pointer runs through its full wrap from requester 4 back to 0.
- A write that differs from the key in a single bit of the key byte is shown to be rejected.

Directed phases cover held grants, non-host operation and mode changes during an access. A long pseudo-random phase then mixes requests, done pulses, host changes and keyed and unkeyed writes.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        MODE_FIXED  = 1'b0,
        MODE_ROTATE = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg
    import arb_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          KEY_W   = 8,
    parameter logic [7:0]  KEY_VAL = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output arb_mode_e         mode_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int KEY_LSB = DATA_W - KEY_W;

    arb_mode_e mode_d, mode_q;
    logic      key_ok;

    always_comb begin
        key_ok = (wdata_i[DATA_W-1:KEY_LSB] == KEY_VAL[KEY_W-1:0]);
        mode_d = mode_q;
        if (we_i && key_ok) begin
            mode_d = arb_mode_e'(wdata_i[0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_FIXED;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode_o  = mode_q;
    assign rdata_o = {{(DATA_W-1){1'b0}}, mode_q};

    // R7: a write without the key leaves the mode untouched
    a_r7_unkeyed_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !key_ok) |=> (mode_q == $past(mode_q)));

    // R7: a keyed write loads data bit 0
    a_r7_keyed_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && key_ok) |=> (rdata_o[0] == $past(wdata_i[0])));

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int N     = 5,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    input  logic [IDX_W-1:0] start_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    int pos;

    // Search from start_i upward with wrap; the nearest hit wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        pos     = 0;
        for (int k = N - 1; k >= 0; k--) begin
            pos = int'(start_i) + k;
            if (pos >= N) begin
                pos = pos - N;
            end
            if (req_i[pos]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(pos);
            end
        end
    end

    // R2: a hit is only reported for an active request
    always_comb begin
        if (found_o) begin
            a_r2_pick_active: assert (req_i[idx_o]);
        end
    end

endmodule

// File: rtl/hostbus_arbiter.sv
module hostbus_arbiter
    import arb_pkg::*;
#(
    parameter int         NUM_REQ = 5,
    parameter int         DATA_W  = 32,
    parameter int         KEY_W   = 8,
    parameter logic [7:0] KEY_VAL = 8'hA5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_mode_i,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               access_done_i,
    input  logic               cfg_we_i,
    input  logic [DATA_W-1:0]  cfg_wdata_i,
    output logic [DATA_W-1:0]  cfg_rdata_o,
    output logic [NUM_REQ-1:0] gnt_o
);

    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REQ - 1);

    typedef struct packed {
        logic [NUM_REQ-1:0] gnt;
        logic [IDX_W-1:0]   ptr;
    } arb_state_t;

    arb_state_t       s_d, s_q;
    arb_mode_e        mode;
    logic             arb_pt;
    logic             found;
    logic [IDX_W-1:0] win_idx;
    logic [IDX_W-1:0] start_idx;

    arb_cfg_reg #(
        .DATA_W  (DATA_W),
        .KEY_W   (KEY_W),
        .KEY_VAL (KEY_VAL)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .mode_o  (mode),
        .rdata_o (cfg_rdata_o)
    );

    assign start_idx = (mode == MODE_ROTATE) ? s_q.ptr : '0;

    arb_pick #(
        .N     (NUM_REQ),
        .IDX_W (IDX_W)
    ) u_pick (
        .req_i   (req_i),
        .start_i (start_idx),
        .found_o (found),
        .idx_o   (win_idx)
    );

    always_comb begin
        s_d    = s_q;
        arb_pt = (s_q.gnt == '0) || access_done_i;
        if (!host_mode_i) begin
            s_d.gnt = '0;
        end else if (arb_pt) begin
            if (found) begin
                s_d.gnt = {{(NUM_REQ-1){1'b0}}, 1'b1} << win_idx;
                if (mode == MODE_ROTATE) begin
                    s_d.ptr = (win_idx == LAST_IDX) ? '0 : win_idx + 1'b1;
                end
            end else begin
                s_d.gnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gnt_o = s_q.gnt;

    // R2: never more than one grant
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R2: a grant issued at an arbitration point goes to a requester
    a_r2_grant_to_req: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode_i && arb_pt && (req_i != '0)) |=> ((gnt_o & $past(req_i)) != '0));

    // R3: requester 0 wins in fixed mode
    a_r3_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode_i && arb_pt && mode == MODE_FIXED && req_i[0]) |=> gnt_o[0]);

    // R5: grant held while an access is in flight
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode_i && (gnt_o != '0) && !access_done_i) |=> (gnt_o == $past(gnt_o)));

    // R6: nothing granted outside host operation
    a_r6_nohost: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode_i |=> (gnt_o == '0));

    // R9: no requests at an arbitration point clears the grant
    a_r9_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode_i && arb_pt && (req_i == '0)) |=> (gnt_o == '0));

endmodule

// File: tb/hostbus_arbiter_tb.sv
module hostbus_arbiter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NREQ       = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_mode_i = 1'b0;
    logic [4:0]  req_i = '0;
    logic        access_done_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] cfg_rdata_o;
    logic [4:0]  gnt_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    int m_mode = 0;
    int m_ptr  = 0;
    int m_gnt  = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostbus_arbiter u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_mode_i   (host_mode_i),
        .req_i         (req_i),
        .access_done_i (access_done_i),
        .cfg_we_i      (cfg_we_i),
        .cfg_wdata_i   (cfg_wdata_i),
        .cfg_rdata_o   (cfg_rdata_o),
        .gnt_o         (gnt_o)
    );

    function automatic logic [4:0] exp_gnt();
        return (m_gnt < 0) ? 5'b0 : (5'b1 << m_gnt);
    endfunction

    task automatic compare();
        logic [4:0]  eg;
        logic [31:0] er;
        eg = exp_gnt();
        er = {31'b0, m_mode[0]};
        n_tests++;
        if (gnt_o !== eg) begin
            n_fail++;
            $display("FAIL %s: gnt actual %b expected %b", cur_req, gnt_o, eg);
        end
        n_tests++;
        if (cfg_rdata_o !== er) begin
            n_fail++;
            $display("FAIL %s: rdata actual %h expected %h", cur_req, cfg_rdata_o, er);
        end
    endtask

    // reference step: applied at the rising edge with the inputs of that cycle
    task automatic model_step(input logic [4:0] r, input logic d, input logic h,
                              input logic we, input logic [31:0] wd);
        bit arb;
        int nmode;
        int start;
        nmode = m_mode;
        if (we && wd[31:24] == 8'hA5) nmode = int'(wd[0]);
        arb = (m_gnt < 0) || d;
        if (!h) begin
            m_gnt = -1;
        end else if (arb) begin
            start = (m_mode == 1) ? m_ptr : 0;
            m_gnt = -1;
            for (int k = 0; k < NREQ; k++) begin
                int p;
                p = (start + k) % NREQ;
                if (m_gnt < 0 && r[p]) m_gnt = p;
            end
            if (m_gnt >= 0 && m_mode == 1) m_ptr = (m_gnt + 1) % NREQ;
        end
        m_mode = nmode;
    endtask

    task automatic cyc(input logic [4:0] r, input logic d, input logic h,
                       input logic we, input logic [31:0] wd);
        req_i         = r;
        access_done_i = d;
        host_mode_i   = h;
        cfg_we_i      = we;
        cfg_wdata_i   = wd;
        @(posedge clk);
        model_step(r, d, h, we, wd);
        @(negedge clk);
        compare();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        compare();

        // R3 fixed priority under several request patterns
        cur_req = "R3";
        cyc(5'b11111, 1'b0, 1'b1, 1'b0, '0);
        cyc(5'b11110, 1'b1, 1'b1, 1'b0, '0);
        cyc(5'b11000, 1'b1, 1'b1, 1'b0, '0);
        cyc(5'b10001, 1'b1, 1'b1, 1'b0, '0);
        cyc(5'b10000, 1'b1, 1'b1, 1'b0, '0);

        // R5 grant held while no done pulse
        cur_req = "R5";
        cyc(5'b00001, 1'b0, 1'b1, 1'b0, '0);
        cyc(5'b00011, 1'b0, 1'b1, 1'b0, '0);
        cyc(5'b00000, 1'b0, 1'b1, 1'b0, '0);
        cyc(5'b00001, 1'b1, 1'b1, 1'b0, '0);

        // R9 no requests at arbitration point
        cur_req = "R9";
        cyc(5'b00000, 1'b1, 1'b1, 1'b0, '0);
        cyc(5'b00000, 1'b0, 1'b1, 1'b0, '0);

        // R7 unkeyed writes discarded, one bit off in the key byte
        cur_req = "R7";
        cyc(5'b00000, 1'b0, 1'b1, 1'b1, 32'hA4000001);
        cyc(5'b00000, 1'b0, 1'b1, 1'b1, 32'h5A000001);
        cyc(5'b00000, 1'b0, 1'b1, 1'b1, 32'h25000001);

        // R8 keyed write with all other bits set reads back only bit 0
        cur_req = "R8";
        cyc(5'b00000, 1'b0, 1'b1, 1'b1, 32'hA5FFFFFF);
        cyc(5'b00000, 1'b0, 1'b1, 1'b0, '0);

        // R4 rotating with all requesters, full wrap twice
        cur_req = "R4";
        for (int i = 0; i < 11; i++) cyc(5'b11111, 1'b1, 1'b1, 1'b0, '0);
        cyc(5'b10011, 1'b1, 1'b1, 1'b0, '0);
        cyc(5'b10011, 1'b1, 1'b1, 1'b0, '0);
        cyc(5'b10011, 1'b1, 1'b1, 1'b0, '0);
        cur_req = "R9";
        cyc(5'b00000, 1'b1, 1'b1, 1'b0, '0);
        cyc(5'b11111, 1'b1, 1'b1, 1'b0, '0);

        // R6 non-host: no grant, mode irrelevant
        cur_req = "R6";
        cyc(5'b11111, 1'b0, 1'b0, 1'b0, '0);
        cyc(5'b11111, 1'b1, 1'b0, 1'b0, '0);
        cyc(5'b00100, 1'b0, 1'b0, 1'b1, 32'hA5000000);
        cyc(5'b00100, 1'b0, 1'b1, 1'b0, '0);

        // R10 mode change written mid-access
        cur_req = "R10";
        cyc(5'b11111, 1'b0, 1'b1, 1'b1, 32'hA5000001);
        cyc(5'b11111, 1'b0, 1'b1, 1'b0, '0);
        cyc(5'b11111, 1'b1, 1'b1, 1'b1, 32'hA5000000);
        cyc(5'b11111, 1'b1, 1'b1, 1'b0, '0);
        cyc(5'b11111, 1'b1, 1'b1, 1'b0, '0);

        // R2 pseudo-random mix
        cur_req = "R2";
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] wd;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wd = {(lfsr[3:0] < 4'd8) ? 8'hA5 : lfsr[15:8], 23'b0, lfsr[5]};
            cyc(lfsr[4:0] & lfsr[12:8], lfsr[6] & lfsr[1],
                (lfsr[15:13] != 3'b000), (lfsr[11:9] == 3'b000), wd);
        end

        finish_run();
    end

endmodule